// File: doc/BRIEF.md
# Memory Sleep Entry and Wake Recovery Controller

This block sits in front of a synchronous burst memory and manages its low-power sleep state. A request line drives it. The line is active high, arrives without regard to the clock, and rests low when nothing drives it. The block brings the request into the clock domain through a synchroniser. After a fixed entry period it declares the memory asleep.

While the memory is asleep, the block refuses every incoming command and forces the data outputs to high impedance. Stored data and the memory's internal state are left untouched. When the request falls, a fixed wake-up window follows. In that window, idle (deselect) and read commands are let through, while writes and burst continuations are refused and flagged. After the window, normal operation resumes.

If the request arrives while a burst is still in flight, the block raises a one-cycle error pulse, because that burst may not finish correctly.

Top module: `slp_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `asleep`, `recovering`, `out_hiz` and `pend_err` are 0, and a valid command is accepted.
- R2: In normal operation every valid command is accepted (`cmd_accept` equals `cmd_valid`), whatever its kind, and `wr_reject` is 0.
- R3: With default parameters, if `sleep_req` goes high between two rising edges, `asleep` reads 0 after the 4th following rising edge and 1 after the 5th. During the entry period before that, commands are still accepted.
- R4: While `asleep` is 1, `out_hiz` is 1 and `cmd_accept` is 0 for every command kind. `burst_busy` has no effect: `pend_err` stays 0.
- R5: With default parameters, if `sleep_req` falls while asleep, `recovering` is 1 after the 3rd and 4th following rising edges. After the 5th, both `recovering` and `asleep` are 0. The recovery window never lasts longer than WAKE_CYC cycles.
- R6: The command kind is encoded as 2'b00 idle/deselect, 2'b01 read, 2'b10 write and 2'b11 burst continue. While `recovering` is 1, kinds 00 and 01 are accepted. Kinds 10 and 11 are refused (`cmd_accept`=0) and raise `wr_reject` in the same cycle. An invalid command is neither accepted nor rejected.
- R7: If the synchronised request is seen in normal operation while `burst_busy` is 1, `pend_err` is 1 for exactly the one cycle after the rising edge at which entry begins (the 3rd edge with defaults).
- R8: If the request falls again before the entry period completes, the block returns to normal operation without ever raising `asleep`.
- R9: If the request rises again during the recovery window, the block re-enters the entry period. `asleep` rises again ENTRY_CYC cycles after the edge at which the new request is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous active-high sleep request |
| burst_busy | input | 1 | A burst operation is still pending |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_kind | input | 2 | Command kind (encoding in R6) |
| cmd_accept | output | 1 | Command is allowed through to the memory |
| wr_reject | output | 1 | Write or continue refused during recovery |
| out_hiz | output | 1 | Force data outputs to high impedance |
| asleep | output | 1 | Memory is in sleep |
| recovering | output | 1 | Wake-up window is running |
| pend_err | output | 1 | Sleep was requested with a burst pending |

## Verification
The bench counts edges exactly around entry and wake. A design with one register too many or too few in the synchroniser or the counters shifts `asleep` or `recovering` by a cycle and fails the edge-by-edge checks. Inside the two-cycle recovery window, it applies all four command kinds. A gate that only looks at writes would let burst-continue commands through, and a gate that stalls everything would refuse reads. A short request pulse tests the entry abort: without it, the memory would fall asleep on a request that has already been withdrawn. A request re-raised during recovery tests the re-entry path, which a design that ignores the request there would miss.

// File: rtl/slp_pkg.sv
package slp_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_ENTER = 2'd1,
      ST_SLEEP = 2'd2,
      ST_WAKE  = 2'd3
   } slp_state_e;

   typedef enum logic [1:0] {
      CMD_IDLE = 2'd0,
      CMD_RD   = 2'd1,
      CMD_WR   = 2'd2,
      CMD_CONT = 2'd3
   } cmd_kind_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_sync = d_async;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '0;
            end else begin
               for (int i = STAGES - 1; i > 0; i--) begin
                  sr[i] <= sr[i-1];
               end
               sr[0] <= d_async;
            end
         end
         assign q_sync = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
   import slp_pkg::*;
#(
   parameter int ENTRY_CYC = 2,
   parameter int WAKE_CYC  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s,
   input  logic       burst_busy,
   output slp_state_e state,
   output logic       pend_err
);

   localparam int MAXC  = max2(ENTRY_CYC, WAKE_CYC);
   localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
   localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYC - 1);
   localparam logic [CNT_W-1:0] WAKE_LAST  = CNT_W'(WAKE_CYC - 1);

   slp_state_e       st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             err_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      err_d = 1'b0;
      unique case (st_q)
         ST_RUN: begin
            if (req_s) begin
               st_d  = ST_ENTER;
               cnt_d = '0;
               err_d = burst_busy;
            end
         end
         ST_ENTER: begin
            if (!req_s) begin
               st_d  = ST_RUN;
               cnt_d = '0;
            end else if (cnt_q == ENTRY_LAST) begin
               st_d  = ST_SLEEP;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_SLEEP: begin
            if (!req_s) begin
               st_d  = ST_WAKE;
               cnt_d = '0;
            end
         end
         ST_WAKE: begin
            if (req_s) begin
               st_d  = ST_ENTER;
               cnt_d = '0;
            end else if (cnt_q == WAKE_LAST) begin
               st_d  = ST_RUN;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: begin
            st_d  = ST_RUN;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_RUN;
         cnt_q    <= '0;
         pend_err <= 1'b0;
      end else begin
         st_q     <= st_d;
         cnt_q    <= cnt_d;
         pend_err <= err_d;
      end
   end

   assign state = st_q;

endmodule

// File: rtl/slp_gate.sv
module slp_gate
   import slp_pkg::*;
(
   input  slp_state_e state,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_kind,
   output logic       cmd_accept,
   output logic       wr_reject,
   output logic       out_hiz,
   output logic       asleep,
   output logic       recovering
);

   logic safe_kind;

   always_comb begin
      safe_kind  = (cmd_kind == CMD_IDLE) || (cmd_kind == CMD_RD);
      cmd_accept = 1'b0;
      wr_reject  = 1'b0;
      unique case (state)
         ST_RUN, ST_ENTER: cmd_accept = cmd_valid;
         ST_WAKE: begin
            cmd_accept = cmd_valid && safe_kind;
            wr_reject  = cmd_valid && !safe_kind;
         end
         default: cmd_accept = 1'b0;
      endcase
   end

   assign asleep     = (state == ST_SLEEP);
   assign out_hiz    = (state == ST_SLEEP);
   assign recovering = (state == ST_WAKE);

endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
   import slp_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ENTRY_CYC   = 2,
   parameter int WAKE_CYC    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       burst_busy,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_kind,
   output logic       cmd_accept,
   output logic       wr_reject,
   output logic       out_hiz,
   output logic       asleep,
   output logic       recovering,
   output logic       pend_err
);

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("slp_ctrl: SYNC_STAGES must be 0..4");
   end
   if (ENTRY_CYC < 1 || ENTRY_CYC > 15) begin : g_bad_entry
      $error("slp_ctrl: ENTRY_CYC must be 1..15");
   end
   if (WAKE_CYC < 1 || WAKE_CYC > 15) begin : g_bad_wake
      $error("slp_ctrl: WAKE_CYC must be 1..15");
   end

   logic       req_s;
   slp_state_e state;

   slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (sleep_req),
      .q_sync  (req_s)
   );

   slp_fsm #(.ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_s      (req_s),
      .burst_busy (burst_busy),
      .state      (state),
      .pend_err   (pend_err)
   );

   slp_gate u_gate (
      .state      (state),
      .cmd_valid  (cmd_valid),
      .cmd_kind   (cmd_kind),
      .cmd_accept (cmd_accept),
      .wr_reject  (wr_reject),
      .out_hiz    (out_hiz),
      .asleep     (asleep),
      .recovering (recovering)
   );

endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk #(
   parameter int WAKE_CYC = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [1:0] cmd_kind,
   input logic       cmd_accept,
   input logic       wr_reject,
   input logic       out_hiz,
   input logic       asleep,
   input logic       recovering,
   input logic       pend_err
);

   localparam int RW = $clog2(WAKE_CYC + 2) + 1;
   logic [RW-1:0] rec_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rec_run <= '0;
      else if (recovering) rec_run <= rec_run + 1'b1;
      else                 rec_run <= '0;
   end

   p_hiz_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> (out_hiz && !cmd_accept && !pend_err));

   p_wr_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (recovering && cmd_valid && cmd_kind[1]) |-> (!cmd_accept && wr_reject));

   p_rd_passes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (recovering && cmd_valid && !cmd_kind[1]) |-> (cmd_accept && !wr_reject));

   p_no_reject_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && !recovering) |-> (!wr_reject && (cmd_accept == cmd_valid)));

   p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(asleep && recovering));

   p_wake_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(asleep) |-> recovering);

   p_wake_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
      recovering |-> (rec_run < RW'(WAKE_CYC)));

   p_sleep_via_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(asleep) |-> !$past(recovering));

endmodule

bind slp_ctrl slp_ctrl_chk #(.WAKE_CYC(WAKE_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_kind   (cmd_kind),
   .cmd_accept (cmd_accept),
   .wr_reject  (wr_reject),
   .out_hiz    (out_hiz),
   .asleep     (asleep),
   .recovering (recovering),
   .pend_err   (pend_err)
);

// File: tb/test_slp_ctrl.sv
module test_slp_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_req = 1'b0;
   logic       burst_busy = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_kind = 2'b00;
   logic       cmd_accept, wr_reject, out_hiz, asleep, recovering, pend_err;

   int n_run = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   slp_ctrl i_slp_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_req  (sleep_req),
      .burst_busy (burst_busy),
      .cmd_valid  (cmd_valid),
      .cmd_kind   (cmd_kind),
      .cmd_accept (cmd_accept),
      .wr_reject  (wr_reject),
      .out_hiz    (out_hiz),
      .asleep     (asleep),
      .recovering (recovering),
      .pend_err   (pend_err)
   );

   // vector bits: {in_recovery, valid, kind[1:0], exp_accept, exp_reject}
   localparam logic [5:0] VEC [10] = '{
      6'b0_1_00_1_0, 6'b0_1_01_1_0, 6'b0_1_10_1_0, 6'b0_1_11_1_0, 6'b0_0_10_0_0,
      6'b1_1_00_1_0, 6'b1_1_01_1_0, 6'b1_1_10_0_1, 6'b1_1_11_0_1, 6'b1_0_10_0_0
   };

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic walk(input bit rec, input string tag);
      for (int i = 0; i < 10; i++) begin
         if (VEC[i][5] == rec) begin
            cmd_valid = VEC[i][4];
            cmd_kind  = VEC[i][3:2];
            #1;
            check({tag, " accept"}, int'(cmd_accept), int'(VEC[i][1]));
            check({tag, " reject"}, int'(wr_reject), int'(VEC[i][0]));
         end
      end
      cmd_valid = 1'b0;
      cmd_kind  = 2'b00;
   endtask

   initial begin
      ticks(3);
      check("R1 asleep in reset", int'(asleep), 0);
      rst_n = 1'b1;
      ticks(1);
      check("R1 asleep", int'(asleep), 0);
      check("R1 recovering", int'(recovering), 0);
      check("R1 out_hiz", int'(out_hiz), 0);
      check("R1 pend_err", int'(pend_err), 0);
      cmd_valid = 1'b1; cmd_kind = 2'b10; #1;
      check("R1 accept", int'(cmd_accept), 1);
      cmd_valid = 1'b0;

      walk(1'b0, "R2");

      // entry with a pending burst
      ticks(1);
      sleep_req = 1'b1; burst_busy = 1'b1;
      ticks(3);
      check("R7 pend_err pulse", int'(pend_err), 1);
      check("R3 asleep early", int'(asleep), 0);
      cmd_valid = 1'b1; cmd_kind = 2'b10; #1;
      check("R3 accept during entry", int'(cmd_accept), 1);
      cmd_valid = 1'b0; burst_busy = 1'b0;
      ticks(1);
      check("R7 pend_err single", int'(pend_err), 0);
      check("R3 asleep edge4", int'(asleep), 0);
      ticks(1);
      check("R3 asleep edge5", int'(asleep), 1);
      check("R4 out_hiz", int'(out_hiz), 1);
      for (int k = 0; k < 4; k++) begin
         cmd_valid = 1'b1; cmd_kind = 2'(k); #1;
         check("R4 refuse while asleep", int'(cmd_accept), 0);
      end
      cmd_valid = 1'b0;
      burst_busy = 1'b1;
      ticks(2);
      check("R4 burst_busy ignored", int'(pend_err), 0);
      check("R4 still asleep", int'(asleep), 1);
      burst_busy = 1'b0;

      // wake
      sleep_req = 1'b0;
      ticks(2);
      check("R5 asleep edge2", int'(asleep), 1);
      check("R5 recovering edge2", int'(recovering), 0);
      ticks(1);
      check("R5 recovering edge3", int'(recovering), 1);
      walk(1'b1, "R6");
      ticks(1);
      check("R5 recovering edge4", int'(recovering), 1);
      ticks(1);
      check("R5 recovering edge5", int'(recovering), 0);
      check("R5 asleep edge5", int'(asleep), 0);
      cmd_valid = 1'b1; cmd_kind = 2'b10; #1;
      check("R2 write after wake", int'(cmd_accept), 1);
      cmd_valid = 1'b0;

      // abort: short request pulse
      ticks(2);
      sleep_req = 1'b1;
      ticks(2);
      sleep_req = 1'b0;
      for (int k = 0; k < 6; k++) begin
         ticks(1);
         check("R8 no sleep after abort", int'(asleep), 0);
      end
      check("R8 no recovery", int'(recovering), 0);

      // re-request during recovery
      sleep_req = 1'b1;
      ticks(5);
      check("R9 asleep first", int'(asleep), 1);
      sleep_req = 1'b0;
      ticks(1);
      sleep_req = 1'b1;
      ticks(2);
      check("R9 recovering", int'(recovering), 1);
      ticks(1);
      check("R9 left recovery", int'(recovering), 0);
      check("R9 not yet asleep", int'(asleep), 0);
      ticks(2);
      check("R9 asleep again", int'(asleep), 1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end

endmodule